// File: doc/BRIEF.md
# Thread Interrupt Priority Context

This block holds the interrupt priority state of one hardware thread. The state is split over four privilege rings: user, OS, hypervisor pool and physical thread. Each ring keeps an 8-bit pending bitmap and a current priority. Priority 0 is the most favoured level and 0xFF means "least favoured" or "none". A presentation request names a ring and a priority. The block turns a priority from 0 to 7 into a one-hot bit, with priority 0 on the most significant bit, and ORs that bit into the ring's bitmap. Priorities above 7 produce no bit.

A ring signals when its most favoured pending priority is numerically lower than its current priority. The two lower rings (user, OS) drive the OS interrupt output. The two upper rings (pool, physical) drive the hypervisor interrupt output. Software reaches the context through a byte-wide register window made of four pages, from hardware (page 0) down to user (page 3). A page can only reach the rings at or below its own privilege. Reading a ring's acknowledge register takes the most favoured pending interrupt. A separate input silences the OS output without touching the hypervisor output.

Top module: `thread_irq_ctx`

## Requirements
- R1: After synchronous reset, every pending bitmap reads 0x00, every current priority reads 0xFF, and both interrupt outputs are low.
- R2: A presentation with priority p in 0..7 sets bit (7 - p) of the addressed ring's pending bitmap. The new bitmap is visible from the cycle after the request.
- R3: A presentation with a priority above 7 changes no bitmap and no output.
- R4: Presentations merge by OR: earlier pending bits of the ring are kept.
- R5: A ring signals when its bitmap is non-zero and the priority of its highest set bit is numerically lower than its current priority. The outputs are registered and follow the state of the same clock edge.
- R6: Rings 0 and 1 drive os_irq. Rings 2 and 3 drive hv_irq.
- R7: A permitted read of register offset 2 (acknowledge) has these effects. It returns the most favoured pending priority, or 0xFF when the bitmap is empty. It clears that pending bit and loads the current priority with that value. The ring then stops signalling for that interrupt.
- R8: The address is {page[7:6], ring[5:4], offset[3:0]}. A page may access a ring only when page + ring <= 3. Writes to other rings are ignored, and reads of them return 0x00.
- R9: Register offset 0 is the pending bitmap, and a write replaces it. Offset 1 is the current priority and is read/write. Writes to offset 2 and accesses to offsets 3..15 are ignored, and those offsets read 0x00.
- R10: A pulse on os_clr forces os_irq low and keeps it low. The block stays in this state until a presentation with priority 0..7 arrives on ring 0 or 1. hv_irq is unaffected.
- R11: Read data appears on reg_rdata with reg_rvalid high in the cycle after reg_rd_en. reg_rvalid is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pres_valid | input | 1 | Presentation request strobe |
| pres_ring | input | 2 | Target ring of the presentation |
| pres_prio | input | 8 | Priority of the presentation |
| os_clr | input | 1 | Silence the OS output |
| reg_rd_en | input | 1 | Register read strobe |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | {page, ring, offset} |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| reg_rvalid | output | 1 | Read data valid |
| os_irq | output | 1 | OS-level interrupt |
| hv_irq | output | 1 | Hypervisor-level interrupt |

## Verification
The assertions check several properties on every cycle. Read data is valid exactly one cycle after a read request. Denied reads return zero, and acknowledge reads return either 0xFF or a priority from 0 to 7. An os_clr pulse drops the OS output, and out-of-range presentations leave both outputs unchanged. Other behaviour depends on accumulated state, and only the bench scenarios can show it: the exact bit position for each priority, OR merging, the threshold against the current priority, which pending bit an acknowledge picks, and the page/ring permission matrix. The bench checks these by sweeping every ring and priority, every current-priority threshold and every page/ring pair.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
  // Priority encoding is fixed by the register layout: eight levels, byte data.
  localparam int PRIO_LEVELS = 8;
  localparam int DW          = 8;
  localparam logic [DW-1:0] PRIO_NONE = '1;

  localparam int OFS_PEND = 0;
  localparam int OFS_CPPR = 1;
  localparam int OFS_ACK  = 2;

  // One-hot pending bit for a priority; zero when the priority is out of range.
  function automatic logic [PRIO_LEVELS-1:0] prio_to_bit(input logic [DW-1:0] p);
    logic [PRIO_LEVELS-1:0] b;
    b = '0;
    for (int i = 0; i < PRIO_LEVELS; i++) begin
      if (p == DW'(i)) b[PRIO_LEVELS-1-i] = 1'b1;
    end
    return b;
  endfunction

  // Most favoured pending priority (leading one from the MSB), PRIO_NONE if empty.
  function automatic logic [DW-1:0] lead_prio(input logic [PRIO_LEVELS-1:0] ipb);
    logic [DW-1:0] r;
    r = PRIO_NONE;
    for (int i = PRIO_LEVELS-1; i >= 0; i--) begin
      if (ipb[PRIO_LEVELS-1-i]) r = DW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/tctx_access_gate.sv
module tctx_access_gate #(
  parameter int NUM_RINGS = 4,
  parameter int OFS_W     = 4,
  localparam int RW       = $clog2(NUM_RINGS),
  localparam int AW       = 2*RW + OFS_W
) (
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  output logic [RW-1:0] ring,
  output logic [OFS_W-1:0] ofs,
  output logic          rd_ok,
  output logic          wr_ok
);
  logic [RW-1:0] page;
  logic          allowed;

  assign page = addr[AW-1 -: RW];
  assign ring = addr[OFS_W +: RW];
  assign ofs  = addr[OFS_W-1:0];

  // Higher page numbers carry less privilege and reach fewer rings.
  assign allowed = (int'(page) + int'(ring)) <= (NUM_RINGS - 1);
  assign rd_ok   = rd_en & allowed;
  assign wr_ok   = wr_en & allowed;
endmodule

// File: rtl/tctx_ring_slot.sv
module tctx_ring_slot
  import tctx_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pres_hit,
  input  logic [DW-1:0]    pres_prio,
  input  logic             wr_hit,
  input  logic             rd_hit,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_val,
  output logic             sig_next,
  output logic             bit_set
);
  logic [PRIO_LEVELS-1:0] ipb_q, ipb_n, new_bit, ack_bit;
  logic [DW-1:0]          cppr_q, cppr_n, lead_q, lead_n;
  logic                   ack;

  assign lead_q  = lead_prio(ipb_q);
  assign new_bit = pres_hit ? prio_to_bit(pres_prio) : '0;
  assign bit_set = |new_bit;
  assign ack     = rd_hit && (ofs == OFS_W'(OFS_ACK)) && (ipb_q != '0);
  assign ack_bit = ack ? prio_to_bit(lead_q) : '0;

  always_comb begin
    case (int'(ofs))
      OFS_PEND: rd_val = DW'(ipb_q);
      OFS_CPPR: rd_val = cppr_q;
      OFS_ACK:  rd_val = lead_q;
      default:  rd_val = '0;
    endcase
  end

  always_comb begin
    ipb_n  = ipb_q;
    cppr_n = cppr_q;
    if (wr_hit && ofs == OFS_W'(OFS_PEND)) ipb_n  = wdata[PRIO_LEVELS-1:0];
    if (wr_hit && ofs == OFS_W'(OFS_CPPR)) cppr_n = wdata;
    if (ack) cppr_n = lead_q;
    ipb_n = (ipb_n & ~ack_bit) | new_bit;
  end

  assign lead_n   = lead_prio(ipb_n);
  assign sig_next = (ipb_n != '0) && (lead_n < cppr_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      ipb_q  <= '0;
      cppr_q <= PRIO_NONE;
    end else begin
      ipb_q  <= ipb_n;
      cppr_q <= cppr_n;
    end
  end
endmodule

// File: rtl/tctx_irq_route.sv
module tctx_irq_route #(
  parameter int NUM_RINGS = 4,
  localparam int HALF     = NUM_RINGS / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_RINGS-1:0] sig_next,
  input  logic [NUM_RINGS-1:0] bit_set,
  input  logic                 os_clr,
  output logic                 os_irq,
  output logic                 hv_irq
);
  logic mask_q, mask_n;

  always_comb begin
    mask_n = mask_q;
    if (|bit_set[HALF-1:0]) mask_n = 1'b0;
    if (os_clr)             mask_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
      os_irq <= 1'b0;
      hv_irq <= 1'b0;
    end else begin
      mask_q <= mask_n;
      os_irq <= (|sig_next[HALF-1:0]) & ~mask_n;
      hv_irq <= |sig_next[NUM_RINGS-1:HALF];
    end
  end
endmodule

// File: rtl/thread_irq_ctx.sv
module thread_irq_ctx
  import tctx_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int OFS_W     = 4,
  localparam int RW       = $clog2(NUM_RINGS),
  localparam int AW       = 2*RW + OFS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pres_valid,
  input  logic [RW-1:0] pres_ring,
  input  logic [DW-1:0] pres_prio,
  input  logic          os_clr,
  input  logic          reg_rd_en,
  input  logic          reg_wr_en,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rvalid,
  output logic          os_irq,
  output logic          hv_irq
);
  logic [RW-1:0]    acc_ring;
  logic [OFS_W-1:0] acc_ofs;
  logic             rd_ok, wr_ok;
  logic [NUM_RINGS-1:0][DW-1:0] slot_rd;
  logic [NUM_RINGS-1:0] sig_next, bit_set;

  tctx_access_gate #(.NUM_RINGS(NUM_RINGS), .OFS_W(OFS_W)) gate_i (
    .rd_en(reg_rd_en), .wr_en(reg_wr_en), .addr(reg_addr),
    .ring(acc_ring), .ofs(acc_ofs), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    tctx_ring_slot #(.OFS_W(OFS_W)) slot_i (
      .clk(clk), .rst(rst),
      .pres_hit(pres_valid && pres_ring == RW'(g)),
      .pres_prio(pres_prio),
      .wr_hit(wr_ok && acc_ring == RW'(g)),
      .rd_hit(rd_ok && acc_ring == RW'(g)),
      .ofs(acc_ofs), .wdata(reg_wdata),
      .rd_val(slot_rd[g]), .sig_next(sig_next[g]), .bit_set(bit_set[g])
    );
  end

  tctx_irq_route #(.NUM_RINGS(NUM_RINGS)) route_i (
    .clk(clk), .rst(rst), .sig_next(sig_next), .bit_set(bit_set),
    .os_clr(os_clr), .os_irq(os_irq), .hv_irq(hv_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd_en;
      reg_rdata  <= rd_ok ? slot_rd[acc_ring] : '0;
    end
  end
endmodule

// File: rtl/tctx_checker.sv
module tctx_checker #(
  parameter int NUM_RINGS = 4,
  parameter int OFS_W     = 4,
  localparam int RW       = $clog2(NUM_RINGS),
  localparam int AW       = 2*RW + OFS_W
) (
  input logic          clk,
  input logic          rst,
  input logic          pres_valid,
  input logic [7:0]    pres_prio,
  input logic          os_clr,
  input logic          reg_rd_en,
  input logic          reg_wr_en,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_rdata,
  input logic          reg_rvalid,
  input logic          os_irq,
  input logic          hv_irq
);
  logic permitted;
  assign permitted = (int'(reg_addr[AW-1 -: RW]) + int'(reg_addr[OFS_W +: RW])) <= (NUM_RINGS - 1);

  assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> reg_rvalid);
  assert_rvalid_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_en |=> !reg_rvalid);
  assert_denied_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && !permitted) |=> (reg_rdata == 8'h00));
  assert_ack_range_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr[OFS_W-1:0] == OFS_W'(2)) |=> (reg_rdata == 8'hFF || reg_rdata < 8'd8));
  assert_os_clr_silences_R10: assert property (@(posedge clk) disable iff (rst)
    (os_clr && !pres_valid) |=> !os_irq);
  assert_out_of_range_inert_R3: assert property (@(posedge clk) disable iff (rst)
    (pres_valid && pres_prio > 8'd7 && !reg_wr_en && !reg_rd_en && !os_clr)
      |=> ($stable(os_irq) && $stable(hv_irq)));
endmodule

bind thread_irq_ctx tctx_checker #(.NUM_RINGS(NUM_RINGS), .OFS_W(OFS_W)) chk_i (
  .clk(clk), .rst(rst), .pres_valid(pres_valid), .pres_prio(pres_prio),
  .os_clr(os_clr), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
  .os_irq(os_irq), .hv_irq(hv_irq)
);

// File: tb/thread_irq_ctx_tb_top.sv
module thread_irq_ctx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pres_valid = 1'b0;
  logic [1:0] pres_ring = '0;
  logic [7:0] pres_prio = '0;
  logic       os_clr = 1'b0;
  logic       reg_rd_en = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reg_rvalid;
  logic       os_irq, hv_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_irq_ctx dut_i (
    .clk(clk), .rst(rst), .pres_valid(pres_valid), .pres_ring(pres_ring),
    .pres_prio(pres_prio), .os_clr(os_clr), .reg_rd_en(reg_rd_en),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .os_irq(os_irq), .hv_irq(hv_irq)
  );

  function automatic logic [7:0] mk(int page, int ring, int ofs);
    return {2'(page), 2'(ring), 4'(ofs)};
  endfunction

  function automatic logic [7:0] bit_of(int p);
    return (p >= 0 && p < 8) ? 8'(1 << (7 - p)) : 8'h00;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic present(int ring, int prio);
    pres_valid = 1'b1; pres_ring = 2'(ring); pres_prio = 8'(prio);
    @(negedge clk);
    pres_valid = 1'b0;
  endtask

  task automatic wr(int page, int ring, int ofs, int val);
    reg_wr_en = 1'b1; reg_addr = mk(page, ring, ofs); reg_wdata = 8'(val);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(int page, int ring, int ofs, output int val);
    reg_rd_en = 1'b1; reg_addr = mk(page, ring, ofs);
    @(negedge clk);
    reg_rd_en = 1'b0;
    val = int'(reg_rdata);
  endtask

  task automatic pulse_clr();
    os_clr = 1'b1;
    @(negedge clk);
    os_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    do_reset();
    // R1: reset state of every ring and both outputs
    for (int r = 0; r < 4; r++) begin
      rd(0, r, 0, v); chk("R1 pending after reset", v, 0);
      rd(0, r, 1, v); chk("R1 cppr after reset", v, 8'hFF);
    end
    chk("R1 os_irq after reset", os_irq, 0);
    chk("R1 hv_irq after reset", hv_irq, 0);

    // R11: rvalid pulse timing
    reg_rd_en = 1'b1; reg_addr = mk(0, 0, 1);
    @(negedge clk); reg_rd_en = 1'b0;
    chk("R11 rvalid after read", reg_rvalid, 1);
    @(negedge clk);
    chk("R11 rvalid idle", reg_rvalid, 0);

    // R2 R3 R5 R6 R7: sweep every ring and priority
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 11; k++) begin
        int p;
        bit s;
        p = (k == 10) ? 255 : k;
        s = (p < 8);
        do_reset();
        present(r, p);
        chk("R6 os_irq routing", os_irq, int'(s && r < 2));
        chk("R6 hv_irq routing", hv_irq, int'(s && r >= 2));
        rd(0, r, 0, v); chk(s ? "R2 pending bit" : "R3 ignored prio", v, bit_of(p));
        rd(0, r, 2, v); chk("R7 ack value", v, s ? p : 255);
        chk("R7 os after ack", os_irq, 0);
        chk("R7 hv after ack", hv_irq, 0);
        rd(0, r, 1, v); chk("R7 cppr after ack", v, s ? p : 255);
        rd(0, r, 0, v); chk("R7 pending after ack", v, 0);
      end
    end

    // R4: merge and ordering of acknowledges
    do_reset();
    present(1, 5); present(1, 2); present(1, 2);
    rd(0, 1, 0, v); chk("R4 merged pending", v, 8'h24);
    rd(0, 1, 2, v); chk("R4 first ack", v, 2);
    rd(0, 1, 0, v); chk("R4 pending left", v, 8'h04);
    chk("R5 prio 5 not below cppr 2", os_irq, 0);
    wr(0, 1, 1, 8'hFF);
    chk("R5 reopened by cppr write", os_irq, 1);
    rd(0, 1, 2, v); chk("R4 second ack", v, 5);

    // R5: threshold against current priority
    for (int c = 0; c < 9; c++) begin
      do_reset();
      wr(0, 2, 1, c);
      present(2, 3);
      chk("R5 threshold", hv_irq, int'(3 < c));
    end

    // R8: page/ring permission matrix
    for (int pg = 0; pg < 4; pg++) begin
      for (int r = 0; r < 4; r++) begin
        bit ok;
        ok = (pg + r) <= 3;
        do_reset();
        wr(pg, r, 1, 8'h40 + pg * 4 + r);
        rd(0, r, 1, v); chk("R8 write permission", v, ok ? (8'h40 + pg * 4 + r) : 8'hFF);
        present(r, 0);
        rd(pg, r, 0, v); chk("R8 read permission", v, ok ? 8'h80 : 0);
      end
    end

    // R9: register layout
    do_reset();
    wr(0, 3, 0, 8'h03);
    rd(0, 3, 0, v); chk("R9 pending replace", v, 8'h03);
    chk("R9 written pending signals", hv_irq, 1);
    wr(0, 3, 2, 8'h00);
    rd(0, 3, 0, v); chk("R9 ack write ignored", v, 8'h03);
    for (int o = 3; o < 16; o++) begin
      wr(0, 3, o, 8'h5A);
      rd(0, 3, o, v); chk("R9 spare offset", v, 0);
    end
    rd(0, 3, 1, v); chk("R9 cppr untouched", v, 8'hFF);

    // R10: OS silence and re-arm
    do_reset();
    present(0, 1); present(3, 1);
    chk("R10 os before clear", os_irq, 1);
    pulse_clr();
    chk("R10 os cleared", os_irq, 0);
    chk("R10 hv kept", hv_irq, 1);
    rd(0, 3, 2, v);
    present(2, 4);
    chk("R10 hv re-raised", hv_irq, 1);
    chk("R10 os stays silent", os_irq, 0);
    present(1, 9);
    chk("R10 no re-arm by ignored prio", os_irq, 0);
    present(0, 6);
    chk("R10 os re-armed", os_irq, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule